// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit timer, a watchdog timeout counter and one 8-bit prescaler that only one of them can use at a time. The timer counts either instruction-cycle enables or synchronized edges on an external count pin. The watchdog counts ticks from a free-running watchdog source. A control bit decides which of the two has the prescaler in front of it. The other one counts its raw events one for one.

The prescaler is a down counter and its value can be read. It lets an event through when its low k bits are all zero just before that event decrements it. The timer uses k = ratio + 1, which gives 1:2 to 1:256. The watchdog uses k = ratio, which gives 1:1 to 1:128. A timer write clears the prescaler when the timer owns it. A watchdog-clear or sleep command clears the prescaler when the watchdog owns it. When the enabled watchdog counter runs out, the block raises a one-cycle reset request. When the timer wraps, the block raises a one-cycle overflow pulse for the interrupt logic.

Top module: `tmr_wd_prescaler`

## Requirements
- R1: While rst_n is low and on release, tmr_q, pre_q, tmr_ovf and wd_rst_req are all 0.
- R2: With pre_to_wd = 0, a timer event advances tmr_q by one only when the low ratio+1 bits of pre_q are zero before that event. Over a run this gives 1:2 (ratio 0) to 1:256 (ratio 7).
- R3: pre_q decrements by one on each event routed into it, wrapping from 0x00 to 0xFF. It changes in no other way except by being cleared to 0.
- R4: With pre_to_wd = 1, every timer event advances tmr_q directly. Each wd_tick decrements the prescaler and reaches the watchdog counter only when the low ratio bits of pre_q are zero, giving 1:1 (ratio 0) to 1:128 (ratio 7).
- R5: With src_pin = 0, timer events are the cycles with cyc_en high. With src_pin = 1, cyc_en is ignored and timer events are edges of cnt_pin.
- R6: cnt_pin passes through two synchronizer flops. edge_rise = 0 counts high-to-low transitions and edge_rise = 1 counts low-to-high transitions. The effect shows on tmr_q on the third rising clock edge after the pin changes.
- R7: tmr_wr loads tmr_wdata into tmr_q on the next edge and overrides a same-cycle increment. It clears pre_q only when pre_to_wd = 0; with pre_to_wd = 1 it leaves pre_q unchanged.
- R8: wd_clr or sleep_cmd clears the watchdog counter. It also clears pre_q only when pre_to_wd = 1; with pre_to_wd = 0 it leaves pre_q unchanged.
- R9: With wd_en high, the 2^WDW-th watchdog count after a clear raises wd_rst_req for one cycle and restarts the count. With wd_en low the count is held at zero and no request is raised.
- R10: When tmr_q increments from 0xFF to 0x00, tmr_ovf is high for exactly the one cycle in which tmr_q first reads 0x00. A write never raises tmr_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per instruction cycle |
| cnt_pin | input | 1 | External count input (asynchronous) |
| wd_tick | input | 1 | Free-running watchdog tick, one cycle per tick |
| ratio | input | 3 | Prescaler ratio select |
| pre_to_wd | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| edge_rise | input | 1 | External edge: 0 falling, 1 rising |
| src_pin | input | 1 | Timer source: 0 cyc_en, 1 cnt_pin edges |
| wd_en | input | 1 | Watchdog enable |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wd_clr | input | 1 | Watchdog clear command |
| sleep_cmd | input | 1 | Sleep command, clears like wd_clr |
| tmr_q | output | 8 | Timer value |
| pre_q | output | 8 | Prescaler value |
| tmr_ovf | output | 1 | One-cycle timer overflow pulse |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The timer is run from dense and sparse instruction-cycle enables at all eight ratios. This separates the prescaler's divide points from a plain counter and shows the 0x00-to-0xFF wrap of pre_q. It is then run from toggling pin patterns under both edge settings, with cyc_en still active, which shows whether the edge polarity and the source multiplexer are right. Owner-swapped runs with random watchdog ticks, writes, clears and sleep commands show which strobe clears the prescaler under which owner. Long uncleared watchdog runs, with wd_en high and then low, show the exact cycle of the reset request. A write of 0xFC followed by steady counting shows the overflow pulse.

// File: rtl/tmr_wd_prescaler.sv
module tmr_wd_prescaler #(
  parameter int TW  = 8,
  parameter int PW  = 8,
  parameter int RW  = 3,
  parameter int WDW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          cnt_pin,
  input  logic          wd_tick,
  input  logic [RW-1:0] ratio,
  input  logic          pre_to_wd,
  input  logic          edge_rise,
  input  logic          src_pin,
  input  logic          wd_en,
  input  logic          tmr_wr,
  input  logic [TW-1:0] tmr_wdata,
  input  logic          wd_clr,
  input  logic          sleep_cmd,
  output logic [TW-1:0] tmr_q,
  output logic [PW-1:0] pre_q,
  output logic          tmr_ovf,
  output logic          wd_rst_req
);
  localparam int SYNC = 2;

  logic [SYNC:0]    pin_sh;
  logic [WDW-1:0]   wd_cnt;
  logic [RW:0]      shift;
  logic [PW:0]      span;
  logic pin_evt, tmr_evt, pre_in, pre_pass, tmr_inc, wd_inc, wd_cmd, pre_clr;

  assign pin_evt  = edge_rise ? (pin_sh[SYNC-1] & ~pin_sh[SYNC])
                              : (~pin_sh[SYNC-1] & pin_sh[SYNC]);
  assign tmr_evt  = src_pin ? pin_evt : cyc_en;
  assign pre_in   = pre_to_wd ? wd_tick : tmr_evt;
  assign shift    = pre_to_wd ? {1'b0, ratio} : {1'b0, ratio} + 1'b1;
  assign span     = ({{PW{1'b0}}, 1'b1} << shift) - {{PW{1'b0}}, 1'b1};
  assign pre_pass = (pre_q & span[PW-1:0]) == '0;
  assign tmr_inc  = pre_to_wd ? tmr_evt : (tmr_evt & pre_pass);
  assign wd_inc   = pre_to_wd ? (wd_tick & pre_pass) : wd_tick;
  assign wd_cmd   = wd_clr | sleep_cmd;
  assign pre_clr  = pre_to_wd ? wd_cmd : tmr_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[SYNC-1:0], cnt_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pre_q <= '0;
    else if (pre_clr) pre_q <= '0;
    else if (pre_in)  pre_q <= pre_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_q   <= '0;
      tmr_ovf <= 1'b0;
    end else begin
      tmr_ovf <= ~tmr_wr & tmr_inc & (&tmr_q);
      if (tmr_wr)       tmr_q <= tmr_wdata;
      else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_cnt     <= '0;
      wd_rst_req <= 1'b0;
    end else if (!wd_en || wd_cmd) begin
      wd_cnt     <= '0;
      wd_rst_req <= 1'b0;
    end else begin
      wd_rst_req <= wd_inc & (&wd_cnt);
      if (wd_inc) wd_cnt <= wd_cnt + 1'b1;
    end

  AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q != $past(pre_q)) |-> (pre_q == $past(pre_q) - 1'b1 || pre_q == '0)); // R3
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> tmr_q == $past(tmr_wdata)); // R7
  AST_WR_CLR_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && !pre_to_wd) |=> pre_q == '0); // R7
  AST_WD_CLR_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    ((wd_clr || sleep_cmd) && pre_to_wd) |=> pre_q == '0); // R8
  AST_WD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !wd_rst_req); // R9
  AST_WD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> wd_cnt == '0); // R9
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |-> tmr_q == '0); // R10
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> !tmr_ovf); // R10
endmodule

// File: tb/tmr_wd_prescaler_test.sv
module tmr_wd_prescaler_test;
  logic clk = 0, rst_n = 0;
  logic cyc_en = 0, cnt_pin = 0, wd_tick = 0, pre_to_wd = 0, edge_rise = 0, src_pin = 0;
  logic wd_en = 0, tmr_wr = 0, wd_clr = 0, sleep_cmd = 0;
  logic [2:0] ratio = 0;
  logic [7:0] tmr_wdata = 0;
  logic [7:0] tmr_q, pre_q;
  logic tmr_ovf, wd_rst_req;

  int vectors = 0, errs = 0;
  string tag = "R1";
  int m_pre, m_tmr, m_wd, m_ovf, m_req, m_s1, m_s2, m_s3;
  int k, pe, pass, tev, tinc, winc, wcmd, pin_in;

  always #5 clk = ~clk;

  tmr_wd_prescaler uut (.*);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_pre = 0; m_tmr = 0; m_wd = 0; m_ovf = 0; m_req = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      pe   = edge_rise ? (m_s2 == 1 && m_s3 == 0) : (m_s2 == 0 && m_s3 == 1);
      tev  = src_pin ? pe : cyc_en;
      k    = pre_to_wd ? ratio : ratio + 1;
      pass = (m_pre % (1 << k)) == 0;
      tinc = pre_to_wd ? tev : (tev && pass);
      winc = pre_to_wd ? (wd_tick && pass) : wd_tick;
      wcmd = wd_clr || sleep_cmd;
      if (pre_to_wd ? wcmd : tmr_wr) m_pre = 0;
      else if (pre_to_wd ? wd_tick : tev) m_pre = (m_pre + 255) % 256;
      m_ovf = (!tmr_wr && tinc && m_tmr == 255);
      if (tmr_wr) m_tmr = tmr_wdata;
      else if (tinc) m_tmr = (m_tmr + 1) % 256;
      if (!wd_en || wcmd) begin m_wd = 0; m_req = 0; end
      else begin
        m_req = winc && m_wd == 255;
        if (winc) m_wd = (m_wd + 1) % 256;
      end
      pin_in = cnt_pin;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end

  task automatic chk(string r, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n) begin
      chk(tag, "tmr_q", tmr_q, m_tmr);
      chk(tag, "pre_q", pre_q, m_pre);
      chk(tag, "tmr_ovf", tmr_ovf, m_ovf);
      chk(tag, "wd_rst_req", wd_rst_req, m_req);
    end

  task automatic run(int n, int p_ce, int p_pin, int p_tick, int p_wr, int p_clr);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cyc_en    = $urandom_range(0, 99) < p_ce;
      wd_tick   = $urandom_range(0, 99) < p_tick;
      if ($urandom_range(0, 99) < p_pin) cnt_pin = ~cnt_pin;
      tmr_wr    = $urandom_range(0, 99) < p_wr;
      tmr_wdata = 8'($urandom_range(0, 255));
      wd_clr    = $urandom_range(0, 99) < p_clr;
      sleep_cmd = $urandom_range(0, 99) < p_clr;
    end
    @(posedge clk); #2;
    cyc_en = 0; wd_tick = 0; tmr_wr = 0; wd_clr = 0; sleep_cmd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "tmr_q in reset", tmr_q, 0);
    chk("R1", "pre_q in reset", pre_q, 0);
    chk("R1", "ovf in reset", tmr_ovf, 0);
    chk("R1", "req in reset", wd_rst_req, 0);
    rst_n = 1;
    for (int r = 0; r < 8; r++) begin
      tag = "R2"; ratio = 3'(r);
      run(200, 70, 0, 0, 0, 0);
      run(200, 100, 0, 0, 0, 0);
    end
    tag = "R3"; ratio = 7; run(600, 100, 0, 0, 0, 0);
    tag = "R5"; src_pin = 1; edge_rise = 0; ratio = 0; run(600, 100, 30, 0, 0, 0);
    tag = "R6"; edge_rise = 1; run(600, 100, 30, 0, 0, 0);
    tag = "R6"; edge_rise = 0; run(300, 0, 60, 0, 0, 0);
    src_pin = 0;
    for (int r = 0; r < 8; r++) begin
      tag = "R4"; pre_to_wd = 1; ratio = 3'(r); wd_en = 1;
      run(300, 80, 0, 60, 0, 0);
    end
    tag = "R7"; pre_to_wd = 0; ratio = 1; run(500, 80, 0, 50, 5, 0);
    tag = "R7"; pre_to_wd = 1; run(500, 80, 0, 80, 5, 0);
    tag = "R8"; pre_to_wd = 1; ratio = 2; run(600, 50, 0, 80, 0, 3);
    tag = "R8"; pre_to_wd = 0; ratio = 2; run(600, 80, 0, 80, 0, 3);
    tag = "R9"; pre_to_wd = 0; wd_en = 1; run(700, 50, 0, 100, 0, 0);
    tag = "R9"; wd_en = 0; run(400, 50, 0, 100, 0, 0);
    tag = "R9"; wd_en = 1; pre_to_wd = 1; ratio = 1; run(1200, 50, 0, 100, 0, 0);
    tag = "R10"; pre_to_wd = 0; ratio = 0; wd_en = 0;
    @(posedge clk); #2; tmr_wr = 1; tmr_wdata = 8'hFC;
    @(posedge clk); #2; tmr_wr = 0;
    run(40, 100, 0, 0, 0, 0);
    @(posedge clk); #2; tmr_wr = 1; tmr_wdata = 8'hFF;
    @(posedge clk); #2; tmr_wr = 1; tmr_wdata = 8'h00;
    @(posedge clk); #2; tmr_wr = 0;
    run(20, 100, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL run did not complete (all requirements) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule